// File: doc/BRIEF.md
# Display Identification I2C Target

This block is an I2C target that hands a 128-byte display identification image to a host. It watches the two bus lines through synchronisers running on the system clock, finds START and STOP conditions, matches a 7-bit address, and then either takes data bytes from the host or sends image bytes back. The only output is an open-drain enable for SDA; the pad logic pulls the line low while that enable is high.

A single byte pointer picks the image byte that goes out next. After a START in the write direction, the first data byte the host sends sets the pointer. Any further bytes the host writes in that transfer are dropped, but each one still moves the pointer forward by one. Each byte the target sends is taken from the pointer's position, and the pointer then moves forward. A parameter picks the image source. One option is an image the block builds itself at elaboration. The other is a flat parallel port that the surrounding logic drives.

Top module: `ddc_target`

## Requirements
- R1: After reset the pointer is 0, the first-byte flag is clear and SDA is released, so a read straight after reset returns image byte 0 first.
- R2: The target acknowledges only its own address (default 7'h50). The address byte is sent MSB first and bit 0 gives the direction, with 1 meaning read. For any other address the target leaves SDA released during the acknowledge clock.
- R3: In a transfer that starts with START and the write direction, the first data byte loads the 8-bit pointer.
- R4: Data bytes written after the first one are discarded, and each one adds one to the pointer.
- R5: Each byte read returns the image byte at the pointer, sent MSB first, and the pointer then adds one. An 8-bit pointer wraps from 255 to 0.
- R6: Pointer values 128 to 255 address the image by their low 7 bits.
- R7: The target acknowledges every data byte the host writes to it.
- R8: When the host does not acknowledge a read byte, the transfer ends and the target keeps SDA released until the next START.
- R9: The pointer survives STOP and repeated START, so a read that follows either one continues from the current pointer.
- R10: A STOP in the middle of a byte abandons the transfer. The target stays released on later clocks and the pointer is unchanged. The target changes SDA only while SCL is low.
- R11: With the internal image, bytes 0 and 7 are 8'h00 and bytes 1 to 6 are 8'hFF. Byte k for 8 <= k <= 126 is (37*k + 11) mod 256. Byte 127 makes the sum of all 128 bytes 0 mod 256.
- R12: With the external image, byte k is bits [8k+7:8k] of the parallel image port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ext_img | input | IMG_BYTES*8 | Parallel image, byte k at bits [8k+7:8k]; used only when EXT_IMAGE=1 |

## Verification
The bench sets the pointer near the top of the 8-bit range and reads across both the 255-to-0 wrap and the image wrap. A design that indexed with all 8 bits would read outside the image, and one that wrapped at 127 would lose the upper pointer bit. It writes extra data bytes after the pointer byte and reads back. This catches a design that stores those bytes as a new pointer, and also one that does not advance the pointer on them. It abandons a byte with STOP and clocks the bus after a host NACK. A target that failed to return to idle would then pull SDA low on clocks that belong to no transfer. A second target that uses the parallel image sits on the same bus at the neighbouring address, which shows that each target acknowledges only its own address.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RX,
      ST_DACK,
      ST_TX,
      ST_MACK
   } ddc_state_e;

   // Generated image body: header pattern, then an arithmetic fill.
   function automatic logic [7:0] ddc_body_byte(int k);
      if (k == 0 || k == 7) return 8'h00;
      if (k >= 1 && k <= 6) return 8'hFF;
      return 8'((k * 37 + 11) % 256);
   endfunction

   // Last byte closes the image so that all bytes sum to zero (R11).
   function automatic logic [7:0] ddc_rom_byte(int k, int n);
      logic [7:0] sum;
      if (k != n - 1) return ddc_body_byte(k);
      sum = 8'h00;
      for (int i = 0; i < n - 1; i++) sum = sum + ddc_body_byte(i);
      return 8'(-sum);
   endfunction

endpackage

// File: rtl/ddc_bus_sync.sv
module ddc_bus_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s    = scl_pipe[STAGES-1];
   assign sda_s    = sda_pipe[STAGES-1];
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   // R10: SDA edges while SCL stays high frame a transfer
   assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/ddc_image.sv
module ddc_image #(
   parameter int IMG_BYTES = 128,
   parameter bit EXT_IMAGE = 1'b0,
   localparam int IDX_W = $clog2(IMG_BYTES)
) (
   input  logic [IMG_BYTES*8-1:0] ext_img,
   input  logic [IDX_W-1:0]       idx,
   output logic [7:0]             rd_byte
);

   generate
      if (EXT_IMAGE) begin : g_ext
         // R12: byte k taken from the parallel port
         assign rd_byte = ext_img[idx*8 +: 8];
      end else begin : g_rom
         logic [7:0] rom [IMG_BYTES];
         logic       unused_ext;
         for (genvar g = 0; g < IMG_BYTES; g++) begin : g_byte
            assign rom[g] = ddc_pkg::ddc_rom_byte(g, IMG_BYTES);
         end
         assign rd_byte    = rom[idx];
         assign unused_ext = ^ext_img;
      end
   endgenerate

endmodule

// File: rtl/ddc_engine.sv
module ddc_engine
   import ddc_pkg::*;
#(
   parameter logic [6:0] ADDR  = 7'h50,
   parameter int         PTR_W = 8,
   parameter int         IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_p,
   input  logic             stop_p,
   input  logic [7:0]       rd_byte,
   output logic [IDX_W-1:0] rd_idx,
   output logic             sda_oe
);

   ddc_state_e       st_q;
   logic [PTR_W-1:0] ptr_q;
   logic [7:0]       sr_q, tx_q;
   logic [3:0]       cnt_q;
   logic             first_q, rw_q, oe_q;
   logic             load_evt;

   assign load_evt = !start_p && !stop_p && st_q == ST_RX && scl_fall &&
                     cnt_q == 4'd8 && first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         ptr_q   <= '0;
         sr_q    <= '0;
         tx_q    <= '0;
         cnt_q   <= '0;
         first_q <= 1'b0;
         rw_q    <= 1'b0;
         oe_q    <= 1'b0;
      end else if (start_p) begin
         st_q  <= ST_ADDR;
         cnt_q <= '0;
         oe_q  <= 1'b0;
      end else if (stop_p) begin
         st_q <= ST_IDLE;
         oe_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: ;
            ST_ADDR: begin
               if (scl_rise && cnt_q < 4'd8) begin
                  sr_q  <= {sr_q[6:0], sda_s};
                  cnt_q <= cnt_q + 4'd1;
               end else if (scl_fall && cnt_q == 4'd8) begin
                  if (sr_q[7:1] == ADDR) begin
                     oe_q <= 1'b1;
                     rw_q <= sr_q[0];
                     st_q <= ST_AACK;
                     if (!sr_q[0]) first_q <= 1'b1;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  cnt_q <= '0;
                  if (rw_q) begin
                     tx_q  <= rd_byte;
                     ptr_q <= ptr_q + 1'b1;
                     oe_q  <= ~rd_byte[7];
                     st_q  <= ST_TX;
                  end else begin
                     oe_q <= 1'b0;
                     st_q <= ST_RX;
                  end
               end
            end
            ST_RX: begin
               if (scl_rise && cnt_q < 4'd8) begin
                  sr_q  <= {sr_q[6:0], sda_s};
                  cnt_q <= cnt_q + 4'd1;
               end else if (scl_fall && cnt_q == 4'd8) begin
                  if (first_q) begin
                     ptr_q   <= PTR_W'(sr_q);
                     first_q <= 1'b0;
                  end else begin
                     ptr_q <= ptr_q + 1'b1;
                  end
                  oe_q <= 1'b1;
                  st_q <= ST_DACK;
               end
            end
            ST_DACK: begin
               if (scl_fall) begin
                  oe_q  <= 1'b0;
                  cnt_q <= '0;
                  st_q  <= ST_RX;
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (cnt_q == 4'd7) begin
                     oe_q  <= 1'b0;
                     cnt_q <= '0;
                     st_q  <= ST_MACK;
                  end else begin
                     tx_q  <= {tx_q[6:0], 1'b0};
                     oe_q  <= ~tx_q[6];
                     cnt_q <= cnt_q + 4'd1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  sr_q[0] <= sda_s;
                  cnt_q   <= 4'd1;
               end else if (scl_fall && cnt_q == 4'd1) begin
                  if (!sr_q[0]) begin
                     tx_q  <= rd_byte;
                     ptr_q <= ptr_q + 1'b1;
                     oe_q  <= ~rd_byte[7];
                     cnt_q <= '0;
                     st_q  <= ST_TX;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_idx = ptr_q[IDX_W-1:0];
   assign sda_oe = oe_q;

   // R2: the address acknowledge is only reached on a match
   p_addr_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_AACK |-> sr_q[7:1] == ADDR);
   // R4: outside a pointer load the pointer only steps by one
   p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(ptr_q) && !$past(load_evt)) |-> ptr_q == PTR_W'($past(ptr_q) + 1'b1));
   // R5: the bit on the bus during SCL high is the byte's current MSB
   p_tx_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TX && scl_s) |-> oe_q == ~tx_q[7]);
   // R7: written data bytes are acknowledged
   p_data_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DACK && scl_s) |-> oe_q);
   // R8: idle means released
   p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_IDLE |-> !oe_q);
   // R10: SDA only moves while SCL is low
   p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oe_q) |-> !scl_s);

endmodule

// File: rtl/ddc_target.sv
module ddc_target #(
   parameter logic [6:0] ADDR        = 7'h50,
   parameter int         IMG_BYTES   = 128,
   parameter int         PTR_W       = 8,
   parameter int         SYNC_STAGES = 2,
   parameter bit         EXT_IMAGE   = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe,
   input  logic [IMG_BYTES*8-1:0] ext_img
);

   localparam int IDX_W = $clog2(IMG_BYTES);

   generate
      if (IMG_BYTES != (1 << IDX_W)) begin : g_bad_size
         $error("ddc_target: IMG_BYTES must be a power of two");
      end
      if (PTR_W < IDX_W || PTR_W > 8) begin : g_bad_ptr
         $error("ddc_target: PTR_W must cover the image and fit a byte");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ddc_target: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
   logic [IDX_W-1:0] rd_idx;
   logic [7:0]       rd_byte;

   ddc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p)
   );

   ddc_image #(.IMG_BYTES(IMG_BYTES), .EXT_IMAGE(EXT_IMAGE)) u_image (
      .ext_img (ext_img),
      .idx     (rd_idx),
      .rd_byte (rd_byte)
   );

   ddc_engine #(.ADDR(ADDR), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p),
      .rd_byte  (rd_byte),
      .rd_idx   (rd_idx),
      .sda_oe   (sda_oe)
   );

endmodule

// File: tb/ddc_target_tb.sv
module ddc_target_tb;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 8;
   localparam int NB         = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic oe0, oe1;
   logic bus_sda;
   logic [NB*8-1:0] ext_img;
   logic [NB*8-1:0] no_img;

   int checks = 0;
   int errors = 0;
   int p0 = 0;
   int p1 = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign bus_sda = sda_m & ~oe0 & ~oe1;
   assign no_img  = '0;

   ddc_target #(.ADDR(7'h50)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
      .sda_oe(oe0), .ext_img(no_img)
   );

   ddc_target #(.ADDR(7'h51), .EXT_IMAGE(1'b1)) u_ext (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda),
      .sda_oe(oe1), .ext_img(ext_img)
   );

   function automatic logic [7:0] body(int k);
      if (k == 0 || k == 7) return 8'h00;
      if (k >= 1 && k <= 6) return 8'hFF;
      return 8'((37 * k + 11) % 256);
   endfunction

   function automatic logic [7:0] exp_int(int k);
      logic [7:0] s;
      if (k != NB - 1) return body(k);
      s = 8'h00;
      for (int i = 0; i < NB - 1; i++) s = s + body(i);
      return 8'(-s);
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic waitq(int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; waitq(1);
      scl_m = 1'b1; waitq(1);
      sda_m = 1'b0; waitq(1);
      scl_m = 1'b0; waitq(1);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; waitq(1);
      scl_m = 1'b1; waitq(1);
      sda_m = 1'b1; waitq(1);
   endtask

   task automatic send_bits(logic [7:0] b, int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; waitq(1);
         scl_m = 1'b1; waitq(2);
         scl_m = 1'b0; waitq(1);
      end
   endtask

   task automatic send_byte(logic [7:0] b, output logic a0, output logic a1);
      send_bits(b, 8);
      sda_m = 1'b1; waitq(1);
      scl_m = 1'b1; waitq(1);
      a0 = oe0; a1 = oe1;
      waitq(1);
      scl_m = 1'b0; waitq(1);
   endtask

   task automatic recv_byte(bit ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         waitq(1);
         scl_m = 1'b1; waitq(1);
         b[i] = bus_sda;
         waitq(1);
         scl_m = 1'b0;
      end
      waitq(1);
      sda_m = ack ? 1'b0 : 1'b1; waitq(1);
      scl_m = 1'b1; waitq(2);
      scl_m = 1'b0; waitq(1);
      sda_m = 1'b1;
   endtask

   // Free SCL pulses with SDA high; returns 1 if target pulled SDA
   task automatic idle_pulses(int n, output logic seen);
      seen = 1'b0;
      sda_m = 1'b1;
      for (int i = 0; i < n; i++) begin
         waitq(1);
         scl_m = 1'b1; waitq(1);
         if (oe0 || oe1) seen = 1'b1;
         waitq(1);
         scl_m = 1'b0;
      end
      waitq(1);
   endtask

   // Write: pointer byte plus extras, all acked by dut0
   task automatic write0(logic [7:0] ptr, int extra, string req);
      logic a0, a1;
      bus_start;
      send_byte({7'h50, 1'b0}, a0, a1);
      chk("R2 addr ack", {7'd0, a0}, 8'd1);
      send_byte(ptr, a0, a1);
      chk("R7 ptr byte ack", {7'd0, a0}, 8'd1);
      p0 = ptr;
      for (int i = 0; i < extra; i++) begin
         send_byte(8'($urandom), a0, a1);
         chk({req, " R7 extra ack"}, {7'd0, a0}, 8'd1);
         p0 = (p0 + 1) % 256;
      end
   endtask

   task automatic read0(int n, string req);
      logic a0, a1;
      logic [7:0] b;
      bus_start;
      send_byte({7'h50, 1'b1}, a0, a1);
      chk("R2 read addr ack", {7'd0, a0}, 8'd1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, b);
         chk({req, " R5 R11 read byte"}, b, exp_int(p0 % NB));
         p0 = (p0 + 1) % 256;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog expired: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic a0, a1, seen;
      logic [7:0] b;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NB; i++) ext_img[i*8 +: 8] = 8'($urandom);

      repeat (10) @(negedge clk);
      chk("R1 oe during reset", {6'd0, oe1, oe0}, 8'd0);
      rst_n = 1'b1;
      waitq(2);
      chk("R1 oe after reset", {6'd0, oe1, oe0}, 8'd0);

      // R1: read from fresh reset starts at byte 0
      read0(4, "R1");
      bus_stop;

      // R8: after host NACK, clocks are ignored
      idle_pulses(9, seen);
      chk("R8 released after nack", {7'd0, seen}, 8'd0);

      // R2: foreign address acked by nobody
      bus_start;
      send_byte({7'h22, 1'b0}, a0, a1);
      chk("R2 foreign nack dut", {7'd0, a0}, 8'd0);
      chk("R2 foreign nack ext", {7'd0, a1}, 8'd0);
      idle_pulses(9, seen);
      chk("R2 stays off after nack", {7'd0, seen}, 8'd0);
      bus_stop;

      // R3 and R9: pointer load, kept across STOP and repeated START
      write0(8'h10, 0, "R3");
      bus_stop;
      read0(1, "R3 R9 after stop");
      read0(1, "R9 repeated start");
      bus_stop;

      // R4: extra writes discarded but advance pointer
      write0(8'h20, 3, "R4");
      read0(2, "R4 after extras");
      bus_stop;

      // R6 and R5 wrap: pointer near top
      write0(8'hFE, 0, "R6");
      read0(4, "R6 R5 wrap");
      bus_stop;
      write0(8'h85, 0, "R6");
      read0(2, "R6 high ptr");
      bus_stop;

      // R10: STOP mid-byte abandons, pointer unchanged
      bus_start;
      send_bits({7'h50, 1'b0}, 4);
      bus_stop;
      idle_pulses(9, seen);
      chk("R10 idle after abort", {7'd0, seen}, 8'd0);
      bus_start;
      send_byte({7'h50, 1'b0}, a0, a1);
      send_bits(8'h33, 5);
      bus_stop;
      read0(2, "R10 ptr kept");
      bus_stop;

      // R12: external image target on neighbouring address
      bus_start;
      send_byte({7'h51, 1'b0}, a0, a1);
      chk("R2 ext addr ack", {7'd0, a1}, 8'd1);
      chk("R2 dut ignores 51", {7'd0, a0}, 8'd0);
      send_byte(8'hFD, a0, a1);
      chk("R7 ext ptr ack", {7'd0, a1}, 8'd1);
      p1 = 8'hFD;
      bus_start;
      send_byte({7'h51, 1'b1}, a0, a1);
      chk("R12 ext read ack", {7'd0, a1}, 8'd1);
      for (int i = 0; i < 5; i++) begin
         recv_byte(i != 4, b);
         chk("R12 ext byte", b, ext_img[(p1 % NB)*8 +: 8]);
         p1 = (p1 + 1) % 256;
      end
      bus_stop;

      // Random mix
      for (int t = 0; t < 24; t++) begin
         if ($urandom % 8 == 0) begin
            bus_start;
            send_byte({7'($urandom % 32), 1'($urandom)}, a0, a1);
            chk("R2 random foreign nack", {6'd0, a1, a0}, 8'd0);
            bus_stop;
         end else begin
            write0(8'($urandom), int'($urandom % 3), "R4 rnd");
            if ($urandom % 2 == 0) bus_stop;
            read0(1 + int'($urandom % 4), "R9 rnd");
            bus_stop;
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule